// File: doc/BRIEF.md
# Shared Encrypt/Decrypt AES Round

This block computes one AES-128 cipher round, in either direction, on a 128-bit state. It takes a state, a round key, a direction bit and a final-round flag. One clock later it returns the next state. A sequencer outside the block feeds it every round of a block in turn, and it can interleave several blocks. The block keeps no key schedule and counts no rounds.

Byte substitution uses a single 256-entry table of 16-bit words. The low byte of each word holds the forward substitution and the high byte holds the inverse. The direction captured with the data picks the half. The row rotation (forward or inverse) is applied as wiring on the table addresses, so the substitution and the rotation together cost one table read. That read is the only register stage.

After the read:
- The forward column mix and the inverse column mix are both built from one GF(2^8) doubling function.
- The final round skips the column mix.
- Key addition is a plain XOR.
- The table contents are computed at elaboration from the field inverse and the affine map. No initialisation file is needed.

Top module: `aes_dual_round`

## Requirements
- R1: While `rst_n` is low, and on the first rising edge after it, `outValid` is 0.
- R2: `outValid` is high exactly one cycle after a cycle with `inValid` high. `stateOut` carries the result of the state, key, direction and final-round flag captured in that cycle. Inputs arriving on consecutive cycles give results on consecutive cycles, in order.
- R3: State byte i (i = 0..15) sits at bits [127-8i -: 8], with row = i mod 4 and column = i div 4. When `decrypt` = 0 and `lastRound` = 0, the result is MixColumns(ShiftRows(SubBytes(state))) XOR key.
- R4: When `decrypt` = 0 and `lastRound` = 1, the result is ShiftRows(SubBytes(state)) XOR key.
- R5: When `decrypt` = 1 and `lastRound` = 1, the result is InvSubBytes(InvShiftRows(state)) XOR key.
- R6: When `decrypt` = 1 and `lastRound` = 0, the result is InvMixColumns(InvSubBytes(InvShiftRows(state)) XOR key).
- R7: Each table word holds the forward substitution in bits [7:0] and the inverse in bits [15:8]. An all-zero state with a zero key and `lastRound` = 1 therefore gives every byte 0x63 when encrypting and every byte 0x52 when decrypting.
- R8: Every output byte of a column mix depends on all four bytes of its column. A column whose four bytes are equal passes the forward mix unchanged.
- R9: `stateOut` keeps its value on every cycle in which `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the valid flag |
| inValid | input | 1 | Input state and key are present this cycle |
| decrypt | input | 1 | 1 selects the inverse round, 0 the forward round |
| lastRound | input | 1 | 1 omits the column mix |
| stateIn | input | 128 | Round input state, byte 0 in the top bits |
| roundKey | input | 128 | Round key, same byte order |
| outValid | output | 1 | `stateOut` holds a fresh result |
| stateOut | output | 128 | Round output state |

## Verification
The checker asserts on every cycle:
- the one-cycle valid timing;
- the reset value of the valid flag;
- that the output holds while no result is valid;
- the all-zero-input substitution values for both directions.

The arithmetic of the four round kinds can only be shown by the bench's scenarios. The bench runs published forward-round vectors for a middle round and for the final round. It chains forward results into inverse rounds so that the inverse rotation, the inverse substitution and the inverse mix are each confirmed against known columns. It also runs a back-to-back burst that alternates direction and round kind on every cycle.

// File: rtl/aes_round_pkg.sv
package aes_round_pkg;

  localparam int BYTE_W    = 8;
  localparam int STATE_W   = 128;
  localparam int NUM_BYTES = STATE_W / BYTE_W;
  localparam int NUM_ROWS  = 4;
  localparam int NUM_COLS  = NUM_BYTES / NUM_ROWS;
  localparam int COL_W     = NUM_ROWS * BYTE_W;
  localparam int ROM_DEPTH = 1 << BYTE_W;
  localparam int ROM_W     = 2 * BYTE_W;

  typedef struct packed {
    logic load;     // capture table reads, key and mode this cycle
    logic addrDec;  // inverse rotation on table addresses
    logic outDec;   // direction of the result being produced
    logic outLast;  // result skips the column mix
  } ctrl_strobe_t;

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (8'h1b & {8{b[7]}});
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, x, y;
    acc = 8'h00; x = a; y = b;
    for (int n = 0; n < 8; n++) begin
      if (y[0]) acc = acc ^ x;
      x = xtime(x);
      y = y >> 1;
    end
    return acc;
  endfunction

  // x^254 is the multiplicative inverse (and maps 0 to 0)
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] r;
    r = 8'h01;
    for (int n = 7; n >= 0; n--) begin
      r = gfMul(r, r);
      if (n != 0) r = gfMul(r, a);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int sh);
    return 8'((v << sh) | (v >> (8 - sh)));
  endfunction

  function automatic logic [7:0] fwdSub(input logic [7:0] a);
    logic [7:0] b;
    b = gfInv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] invSub(input logic [7:0] a);
    return gfInv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
  endfunction

  function automatic logic [ROM_W-1:0] tableWord(input logic [7:0] a);
    return {invSub(a), fwdSub(a)};
  endfunction

  function automatic logic [COL_W-1:0] mixFwd(input logic [COL_W-1:0] c);
    logic [7:0] a0, a1, a2, a3, t;
    {a0, a1, a2, a3} = c;
    t = a0 ^ a1 ^ a2 ^ a3;
    return {a0 ^ t ^ xtime(a0 ^ a1), a1 ^ t ^ xtime(a1 ^ a2),
            a2 ^ t ^ xtime(a2 ^ a3), a3 ^ t ^ xtime(a3 ^ a0)};
  endfunction

  // inverse mix = forward mix after a pre-pass of quadrupled pair sums
  function automatic logic [COL_W-1:0] mixInv(input logic [COL_W-1:0] c);
    logic [7:0] a0, a1, a2, a3, u, v;
    {a0, a1, a2, a3} = c;
    u = xtime(xtime(a0 ^ a2));
    v = xtime(xtime(a1 ^ a3));
    return mixFwd({a0 ^ u, a1 ^ v, a2 ^ u, a3 ^ v});
  endfunction

endpackage

// File: rtl/aes_dual_sbox_rom.sv
module aes_dual_sbox_rom
  import aes_round_pkg::*;
#(
  parameter int PORTS = NUM_BYTES
) (
  input  logic                   clk,
  input  logic                   en,
  input  logic [PORTS*BYTE_W-1:0] addr,
  output logic [PORTS*ROM_W-1:0]  word
);

  logic [ROM_W-1:0] tbl [ROM_DEPTH];

  for (genvar gi = 0; gi < ROM_DEPTH; gi++) begin : g_fill
    assign tbl[gi] = tableWord(BYTE_W'(gi));
  end

  for (genvar gp = 0; gp < PORTS; gp++) begin : g_port
    always_ff @(posedge clk) begin
      if (en) word[gp*ROM_W +: ROM_W] <= tbl[addr[gp*BYTE_W +: BYTE_W]];
    end
  end

endmodule

// File: rtl/aes_round_ctrl.sv
module aes_round_ctrl
  import aes_round_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic         decrypt,
  input  logic         lastRound,
  output ctrl_strobe_t strb,
  output logic         outValid
);

  logic decQ, lastQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  always_ff @(posedge clk) begin
    if (inValid) begin
      decQ  <= decrypt;
      lastQ <= lastRound;
    end
  end

  always_comb begin
    strb.load    = inValid;
    strb.addrDec = decrypt;
    strb.outDec  = decQ;
    strb.outLast = lastQ;
  end

endmodule

// File: rtl/aes_round_dp.sv
module aes_round_dp
  import aes_round_pkg::*;
(
  input  logic               clk,
  input  ctrl_strobe_t       strb,
  input  logic [STATE_W-1:0] stateIn,
  input  logic [STATE_W-1:0] roundKey,
  output logic [STATE_W-1:0] stateOut
);

  logic [NUM_BYTES*BYTE_W-1:0] romAddr;
  logic [NUM_BYTES*ROM_W-1:0]  romWord;
  logic [STATE_W-1:0]          keyQ, subState, keyed, fwdMixed, invMixed;

  // rotation folded into the table addresses: lane (r,c) reads the source byte
  for (genvar gk = 0; gk < NUM_BYTES; gk++) begin : g_lane
    localparam int ROW     = gk % NUM_ROWS;
    localparam int COL     = gk / NUM_ROWS;
    localparam int FWD_SRC = NUM_ROWS * ((COL + ROW) % NUM_COLS) + ROW;
    localparam int INV_SRC = NUM_ROWS * ((COL + NUM_COLS - ROW) % NUM_COLS) + ROW;
    assign romAddr[gk*BYTE_W +: BYTE_W] = strb.addrDec
        ? stateIn[STATE_W-1-INV_SRC*BYTE_W -: BYTE_W]
        : stateIn[STATE_W-1-FWD_SRC*BYTE_W -: BYTE_W];
    assign subState[STATE_W-1-gk*BYTE_W -: BYTE_W] = strb.outDec
        ? romWord[gk*ROM_W + BYTE_W +: BYTE_W]
        : romWord[gk*ROM_W +: BYTE_W];
  end

  aes_dual_sbox_rom #(.PORTS(NUM_BYTES)) i_rom (
    .clk (clk),
    .en  (strb.load),
    .addr(romAddr),
    .word(romWord)
  );

  always_ff @(posedge clk) begin
    if (strb.load) keyQ <= roundKey;
  end

  assign keyed = subState ^ keyQ;

  for (genvar gc = 0; gc < NUM_COLS; gc++) begin : g_col
    localparam int HI = STATE_W - 1 - gc * COL_W;
    assign fwdMixed[HI -: COL_W] = mixFwd(subState[HI -: COL_W]);
    assign invMixed[HI -: COL_W] = mixInv(keyed[HI -: COL_W]);
  end

  always_comb begin
    if (!strb.outDec) stateOut = (strb.outLast ? subState : fwdMixed) ^ keyQ;
    else              stateOut = strb.outLast ? keyed : invMixed;
  end

endmodule

// File: rtl/aes_dual_round.sv
module aes_dual_round
  import aes_round_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic               decrypt,
  input  logic               lastRound,
  input  logic [STATE_W-1:0] stateIn,
  input  logic [STATE_W-1:0] roundKey,
  output logic               outValid,
  output logic [STATE_W-1:0] stateOut
);

  ctrl_strobe_t strb;

  aes_round_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .decrypt  (decrypt),
    .lastRound(lastRound),
    .strb     (strb),
    .outValid (outValid)
  );

  aes_round_dp i_dp (
    .clk     (clk),
    .strb    (strb),
    .stateIn (stateIn),
    .roundKey(roundKey),
    .stateOut(stateOut)
  );

endmodule

// File: rtl/aes_dual_round_chk.sv
module aes_dual_round_chk
  import aes_round_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               inValid,
  input logic               decrypt,
  input logic               lastRound,
  input logic [STATE_W-1:0] stateIn,
  input logic [STATE_W-1:0] roundKey,
  input logic               outValid,
  input logic [STATE_W-1:0] stateOut
);

  // R1
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !outValid);

  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> $stable(stateOut));

  // R7
  a_r7_zero_sub: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inValid && lastRound && stateIn == '0 && roundKey == '0) |->
      stateOut == ($past(decrypt) ? {NUM_BYTES{8'h52}} : {NUM_BYTES{8'h63}}));

endmodule

bind aes_dual_round aes_dual_round_chk i_chk (.*);

// File: tb/test_aes_dual_round.sv
module test_aes_dual_round;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic         decrypt = 1'b0;
  logic         lastRound = 1'b0;
  logic [127:0] stateIn = '0;
  logic [127:0] roundKey = '0;
  logic         outValid;
  logic [127:0] stateOut;

  always #4 clk = ~clk;

  aes_dual_round i_aes_dual_round (.*);

  typedef struct {
    logic [127:0] exp;
    string        tag;
    bit           chk;
  } item_t;

  item_t        sb[$];
  int           total = 0;
  int           fails = 0;
  logic [127:0] lastOut = '0;

  // known round values
  localparam logic [127:0] S1  = 128'h00102030405060708090a0b0c0d0e0f0;
  localparam logic [127:0] K1  = 128'hd6aa74fdd2af72fadaa678f1d6ab76fe;
  localparam logic [127:0] R1O = 128'h89d810e8855ace682d1843d8cb128fe4;
  localparam logic [127:0] M1  = 128'h5f72641557f5bc92f7be3b291db9f91a;
  localparam logic [127:0] P1  = 128'h6353e08c0960e104cd70b751bacad0e7;
  localparam logic [127:0] S10 = 128'hbd6e7c3df2b5779e0b61216e8b10b689;
  localparam logic [127:0] K10 = 128'h13111d7fe3944a17f307a78b4d2b30c5;
  localparam logic [127:0] O10 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] KC  = {4{32'h8e4da1bc}};
  localparam logic [127:0] KCI = {4{32'hdb135345}};

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] s, input logic [127:0] k, input bit dec,
                      input bit last, input logic [127:0] exp, input string tag, input bit chk);
    item_t it;
    @(negedge clk);
    stateIn = s; roundKey = k; decrypt = dec; lastRound = last; inValid = 1'b1;
    it.exp = exp; it.tag = tag; it.chk = chk;
    sb.push_back(it);
  endtask

  task automatic drain();
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    #1;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && outValid) begin
        lastOut = stateOut;
        if (sb.size() == 0) begin
          check("R2 unexpected result", stateOut, 'x);
        end else begin
          item_t it;
          it = sb.pop_front();
          if (it.chk) check(it.tag, stateOut, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [127:0] x;
    logic [127:0] held;
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", {127'b0, outValid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outValid after reset", {127'b0, outValid}, '0);

    // R7 table halves, R8 equal columns pass the mix
    send('0, '0, 0, 1, {16{8'h63}}, "R7 fwd half", 1);
    send('0, '0, 1, 1, {16{8'h52}}, "R7 inv half", 1);
    send('0, '0, 0, 0, {16{8'h63}}, "R8 equal column mix", 1);
    drain();

    // R3 middle round, R4 final round
    send(S1, K1, 0, 0, R1O, "R3 forward middle round", 1);
    send(S1, '0, 0, 0, M1, "R8 forward mix columns", 1);
    send(S10, K10, 0, 1, O10, "R4 forward final round", 1);
    send(S1, '0, 0, 1, P1, "R4 rotate and substitute", 1);
    drain();

    // R5 inverse final round undoes rotation and substitution
    send(P1, K1, 1, 1, S1 ^ K1, "R5 inverse final round", 1);
    send(P1, '0, 1, 1, S1, "R5 inverse final zero key", 1);
    drain();

    // R6 inverse middle round via chained forward result
    send(M1, '0, 0, 1, '0, "capture", 0);
    drain();
    x = lastOut;
    send(x, '0, 1, 0, P1, "R6 inverse middle zero key", 1);
    send(x, KC, 1, 0, P1 ^ KCI, "R6 inverse middle keyed", 1);
    drain();

    // R2 back-to-back, mode and flag changing every cycle
    send(S10, K10, 0, 1, O10, "R2 burst 0", 1);
    send(P1, K1, 1, 1, S1 ^ K1, "R2 burst 1", 1);
    send(S1, K1, 0, 0, R1O, "R2 burst 2", 1);
    send(x, '0, 1, 0, P1, "R2 burst 3", 1);
    send('0, '0, 1, 1, {16{8'h52}}, "R2 burst 4", 1);
    drain();
    check("R2 queue drained", {96'b0, 32'(sb.size())}, '0);

    // R9 output holds while idle
    held = stateOut;
    repeat (4) @(negedge clk);
    check("R9 hold while idle", stateOut, held);
    check("R9 valid low while idle", {127'b0, outValid}, '0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule